// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block is the system-control coprocessor that sits beside the integer pipeline of a small 32-bit RISC core. It keeps five architectural registers: a mode/enable register, a cause register, the saved exception program counter, a free-running cycle counter and a compare value for that counter. Software reaches all of them through a single register-move port: a 5-bit register number selects the target, a write strobe moves a 32-bit word into it, and the read data for the selected number is returned combinationally.

The pipeline reports synchronous exceptions with a valid strobe, a 5-bit code and the PC of the faulting instruction. Six external interrupt lines, two software-settable interrupt levels and the internal timer make up eight interrupt levels, each gated by its own mask bit and by a global enable. While the exception-level flag is set, no interrupt is accepted and the saved PC is frozen, so a running handler is never disturbed. The block tells the pipeline when an interrupt is being taken, exposes the saved PC as the handler-return target, and drives the current mode bits.

The pipeline uses `irq_take` to redirect fetch to the handler; the coprocessor records the event in the same clock edge. A handler-return strobe clears the exception-level flag.

Top module: `sysctl_cop`

## Requirements
- R1: After reset the Status register (number 12) reads 0x0000FF11 and Cause (number 13) reads 0; `int_enable` and `user_mode` are 1 and `exc_level` is 0.
- R2: Status keeps writable fields at bit 0 (interrupt enable), bit 1 (exception level), bit 4 (user mode, 1 = user) and bits 15:8 (interrupt mask, bit 8+k for level k); every other Status bit reads 0. `int_enable`, `exc_level` and `user_mode` show bits 0, 1 and 4.
- R3: When `exc_valid` is high at a clock edge with the exception level 0, after that edge the exception level is 1, Cause bits 6:2 hold `exc_code` and EPC (number 14, also on `ret_pc`) holds `cur_pc`.
- R4: An exception taken while the exception level is already 1 updates Cause bits 6:2 but leaves EPC unchanged.
- R5: Cause bits 15:8 show the pending levels: bits 9:8 the two software levels, bit 10+i line `hw_irq[i]` for i = 0..4, bit 15 `hw_irq[5]` ORed with the timer pending flag. `irq_take` is 1 exactly when some pending bit and its mask bit are both 1, interrupt enable is 1, exception level is 0 and `exc_valid` is 0.
- R6: At an edge where `irq_take` is 1 the block sets exception level 1, writes code 0 to Cause bits 6:2 and copies `cur_pc` into EPC.
- R7: When `exc_valid` and a pending enabled interrupt occur in the same cycle, `irq_take` is 0 and the recorded code is `exc_code`.
- R8: A write to Cause changes only bits 9:8 (the software levels); all other Cause bits ignore the write.
- R9: Count (number 9) increments by one each clock and wraps from 0xFFFFFFFF to 0; a write to Count loads the written value in place of the increment in that cycle. Compare (number 11) reads back the last value written.
- R10: When Count equals Compare at an edge, the timer pending flag (Cause bit 15) is 1 after the next edge and stays 1 until Compare is written, which clears it.
- R11: A pulse on `eret` clears the exception level; `ret_pc` keeps the EPC value.
- R12: Register numbers other than 9, 11, 12, 13 and 14 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 5 | Register number for move-to and move-from |
| reg_we | input | 1 | Move-to write strobe |
| reg_wdata | input | 32 | Move-to write data |
| reg_rdata | output | 32 | Move-from read data of the selected register |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code of the requested exception |
| cur_pc | input | 32 | PC of the current instruction |
| hw_irq | input | 6 | External interrupt lines |
| eret | input | 1 | Handler-return strobe, clears exception level |
| irq_take | output | 1 | Interrupt is being taken this cycle |
| ret_pc | output | 32 | Saved PC for the handler return |
| user_mode | output | 1 | Status user-mode bit |
| exc_level | output | 1 | Status exception-level bit |
| int_enable | output | 1 | Status interrupt-enable bit |

## Verification
The bench sweeps every external line against every single-bit mask, so a level wired to the wrong Cause or mask position raises `irq_take` for the wrong pair, and it walks every defined exception code so a misplaced code field reads back shifted. It fires a second exception inside a handler to catch an EPC that is overwritten when it should be frozen, and collides an exception with an enabled interrupt to catch inverted priority. The timer is sampled at the cycle before and after the match, which exposes a missing pipeline stage or a flag that is not sticky, and Count is loaded just below its top to exercise the wrap and the write-over-increment priority. Writes of all ones to Cause and Status catch read-only bits that accept data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN     = 32;
  localparam int SEL_W    = 5;
  localparam int IRQ_LVLS = 8;
  localparam int SW_LVLS  = 2;
  localparam int HW_LVLS  = IRQ_LVLS - SW_LVLS;
  localparam int CODE_W   = 5;
  localparam int CODE_LO  = 2;

  localparam logic [SEL_W-1:0] SEL_COUNT = 5'd9;
  localparam logic [SEL_W-1:0] SEL_CMP   = 5'd11;
  localparam logic [SEL_W-1:0] SEL_STAT  = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC   = 5'd14;

  localparam int ST_IE      = 0;
  localparam int ST_EXL     = 1;
  localparam int ST_UM      = 4;
  localparam int LVL_LO     = 8;

  localparam logic [CODE_W-1:0] CODE_INTR = '0;
endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         pend
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic         pend_q, pend_d;
  logic         hit;

  always_comb begin
    hit    = (cnt_q == cmp_q);
    cnt_d  = cnt_we ? wdata : cnt_q + ONE;
    cmp_d  = cmp_we ? wdata : cmp_q;
    pend_d = cmp_we ? 1'b0 : (pend_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
    end
  end

  assign count   = cnt_q;
  assign compare = cmp_q;
  assign pend    = pend_q;

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> count == $past(count) + ONE);
  // R9
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(wdata));
  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !pend);
  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == compare) && !cmp_we |=> pend);
endmodule

// File: rtl/sysctl_intr.sv
module sysctl_intr #(
  parameter int LVLS = 8
) (
  input  logic [LVLS-1:0] pending,
  input  logic [LVLS-1:0] mask,
  input  logic            ie,
  input  logic            exl,
  output logic            req
);
  logic [LVLS-1:0] live;

  always_comb begin
    live = pending & mask;
    req  = ie && !exl && (|live);
  end
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic                reg_we,
  input  logic [XLEN-1:0]     reg_wdata,
  output logic [XLEN-1:0]     reg_rdata,
  input  logic                exc_valid,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [HW_LVLS-1:0]  hw_irq,
  input  logic                eret,
  output logic                irq_take,
  output logic [XLEN-1:0]     ret_pc,
  output logic                user_mode,
  output logic                exc_level,
  output logic                int_enable
);
  logic rst_ni;

  logic                ie_q, ie_d, exl_q, exl_d, um_q, um_d;
  logic [IRQ_LVLS-1:0] mask_q, mask_d;
  logic [SW_LVLS-1:0]  sw_q, sw_d;
  logic [CODE_W-1:0]   code_q, code_d;
  logic [XLEN-1:0]     epc_q, epc_d;

  logic st_we, cause_we, epc_we, cnt_we, cmp_we;
  logic [XLEN-1:0] count, compare, status_vec, cause_vec;
  logic            tmr_pend, irq_req, take_evt;
  logic [IRQ_LVLS-1:0] pend_vec;

  sysctl_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  always_comb begin
    st_we    = reg_we && (reg_sel == SEL_STAT);
    cause_we = reg_we && (reg_sel == SEL_CAUSE);
    epc_we   = reg_we && (reg_sel == SEL_EPC);
    cnt_we   = reg_we && (reg_sel == SEL_COUNT);
    cmp_we   = reg_we && (reg_sel == SEL_CMP);
  end

  sysctl_timer #(.W(XLEN)) i_timer (
    .clk(clk), .rst_n(rst_ni), .cnt_we(cnt_we), .cmp_we(cmp_we),
    .wdata(reg_wdata), .count(count), .compare(compare), .pend(tmr_pend)
  );

  assign pend_vec = {hw_irq[HW_LVLS-1] | tmr_pend, hw_irq[HW_LVLS-2:0], sw_q};

  sysctl_intr #(.LVLS(IRQ_LVLS)) i_intr (
    .pending(pend_vec), .mask(mask_q), .ie(ie_q), .exl(exl_q), .req(irq_req)
  );

  always_comb begin
    irq_take = irq_req && !exc_valid;
    take_evt = exc_valid || irq_req;

    ie_d   = st_we ? reg_wdata[ST_IE] : ie_q;
    um_d   = st_we ? reg_wdata[ST_UM] : um_q;
    mask_d = st_we ? reg_wdata[LVL_LO +: IRQ_LVLS] : mask_q;
    sw_d   = cause_we ? reg_wdata[LVL_LO +: SW_LVLS] : sw_q;

    if (take_evt)   exl_d = 1'b1;
    else if (st_we) exl_d = reg_wdata[ST_EXL];
    else if (eret)  exl_d = 1'b0;
    else            exl_d = exl_q;

    if (exc_valid)    code_d = exc_code;
    else if (irq_req) code_d = CODE_INTR;
    else              code_d = code_q;

    if (take_evt && !exl_q) epc_d = cur_pc;
    else if (epc_we)        epc_d = reg_wdata;
    else                    epc_d = epc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b1;
      exl_q  <= 1'b0;
      um_q   <= 1'b1;
      mask_q <= '1;
      sw_q   <= '0;
      code_q <= '0;
      epc_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      exl_q  <= exl_d;
      um_q   <= um_d;
      mask_q <= mask_d;
      sw_q   <= sw_d;
      code_q <= code_d;
      epc_q  <= epc_d;
    end
  end

  always_comb begin
    status_vec = '0;
    status_vec[ST_IE]  = ie_q;
    status_vec[ST_EXL] = exl_q;
    status_vec[ST_UM]  = um_q;
    status_vec[LVL_LO +: IRQ_LVLS] = mask_q;
    cause_vec = '0;
    cause_vec[CODE_LO +: CODE_W]  = code_q;
    cause_vec[LVL_LO +: IRQ_LVLS] = pend_vec;
    case (reg_sel)
      SEL_STAT:  reg_rdata = status_vec;
      SEL_CAUSE: reg_rdata = cause_vec;
      SEL_EPC:   reg_rdata = epc_q;
      SEL_COUNT: reg_rdata = count;
      SEL_CMP:   reg_rdata = compare;
      default:   reg_rdata = '0;
    endcase
  end

  assign ret_pc     = epc_q;
  assign user_mode  = um_q;
  assign exc_level  = exl_q;
  assign int_enable = ie_q;

  // R3
  exc_enter_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    exc_valid |=> exc_level && (cause_vec[CODE_LO +: CODE_W] == $past(exc_code)));
  // R4
  epc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    exc_level && exc_valid && !epc_we |=> $stable(ret_pc));
  // R6
  irq_enter_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_take |=> exc_level && (ret_pc == $past(cur_pc)) && (code_q == CODE_INTR));
  // R5
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (exc_level || !int_enable) |-> !irq_take);
  // R11
  eret_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    eret && !take_evt && !st_we |=> !exc_level && $stable(ret_pc));
endmodule

// File: tb/test_sysctl_cop.sv
module test_sysctl_cop;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] cur_pc;
  logic [5:0]  hw_irq;
  logic        eret;
  logic        irq_take;
  logic [31:0] ret_pc;
  logic        user_mode, exc_level, int_enable;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sysctl_cop i_sysctl_cop (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_valid(exc_valid),
    .exc_code(exc_code), .cur_pc(cur_pc), .hw_irq(hw_irq), .eret(eret),
    .irq_take(irq_take), .ret_pc(ret_pc), .user_mode(user_mode),
    .exc_level(exc_level), .int_enable(int_enable)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_wdata = data; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0]  exp_code;
    logic [31:0] exp_epc;
    rst_n = 1'b0; reg_sel = '0; reg_we = 1'b0; reg_wdata = '0;
    exc_valid = 1'b0; exc_code = '0; cur_pc = '0; hw_irq = '0; eret = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    rd("R1 status", 5'd12, 32'h0000_FF11);
    rd("R1 cause", 5'd13, 32'h0);
    check("R1 modes", {29'd0, user_mode, int_enable, exc_level}, 32'h6);

    // R12 unmapped numbers
    wr(5'd3, 32'hFFFF_FFFF);
    rd("R12 read unmapped", 5'd3, 32'h0);
    rd("R12 status untouched", 5'd12, 32'h0000_FF11);
    rd("R12 read zero", 5'd0, 32'h0);

    // R2 status fields
    wr(5'd12, 32'hFFFF_FFFF);
    rd("R2 all ones", 5'd12, 32'h0000_FF13);
    check("R2 modes ones", {29'd0, user_mode, int_enable, exc_level}, 32'h7);
    wr(5'd12, 32'h0000_0000);
    rd("R2 zero", 5'd12, 32'h0);
    check("R2 modes zero", {29'd0, user_mode, int_enable, exc_level}, 32'h0);
    wr(5'd12, 32'h0000_A5E1);
    rd("R2 pattern", 5'd12, 32'h0000_A501);
    wr(5'd12, 32'h0);

    // R8 cause write mask
    wr(5'd13, 32'hFFFF_FFFF);
    rd("R8 cause ones", 5'd13, 32'h0000_0300);
    wr(5'd13, 32'h0);
    rd("R8 cause zero", 5'd13, 32'h0);

    // R9 count wrap, write priority, compare readback
    wr(5'd9, 32'hFFFF_FFFE);
    rd("R9 load", 5'd9, 32'hFFFF_FFFE);
    tick(); rd("R9 top", 5'd9, 32'hFFFF_FFFF);
    tick(); rd("R9 wrap", 5'd9, 32'h0);
    wr(5'd11, 32'h0000_1234);
    rd("R9 compare", 5'd11, 32'h0000_1234);
    wr(5'd9, 32'h0);
    for (int k = 1; k <= 20; k++) begin
      tick();
      rd("R9 step", 5'd9, 32'(k));
    end

    // R10 timer match
    wr(5'd11, 32'd40);
    wr(5'd9, 32'd30);
    repeat (10) tick();
    rd("R10 count at match", 5'd9, 32'd40);
    rd("R10 not yet", 5'd13, 32'h0);
    tick();
    rd("R10 pending", 5'd13, 32'h0000_8000);
    repeat (5) tick();
    rd("R10 sticky", 5'd13, 32'h0000_8000);
    wr(5'd11, 32'hFFFF_0000);
    rd("R10 cleared", 5'd13, 32'h0);
    wr(5'd9, 32'h0);

    // R3 every defined code
    for (int c = 4; c <= 14; c++) begin
      wr(5'd12, 32'h0);
      exc_valid = 1'b1; exc_code = 5'(c); cur_pc = 32'h1000 + 32'(c) * 4;
      tick();
      exc_valid = 1'b0;
      check("R3 level", {31'd0, exc_level}, 32'h1);
      rd("R3 code", 5'd13, 32'(c) << 2);
      rd("R3 epc", 5'd14, 32'h1000 + 32'(c) * 4);
    end
    exp_epc = 32'h1000 + 14 * 4;

    // R4 nested exception keeps EPC
    exc_valid = 1'b1; exc_code = 5'd12; cur_pc = 32'hDEAD_0000;
    tick();
    exc_valid = 1'b0;
    rd("R4 code", 5'd13, 32'd12 << 2);
    check("R4 epc frozen", ret_pc, exp_epc);

    // R11 return
    eret = 1'b1; tick(); eret = 1'b0;
    check("R11 level cleared", {31'd0, exc_level}, 32'h0);
    check("R11 ret_pc", ret_pc, exp_epc);
    exp_code = 5'd12;

    // R5 / R6 line-by-mask sweep
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 6; i++) begin
        bit hit;
        hit = (j == i + 2);
        wr(5'd12, (32'h1 << (8 + j)) | 32'h1);
        hw_irq = 6'(1 << i);
        cur_pc = 32'h2000 + 32'(j * 16 + i);
        #1;
        check("R5 irq_take", {31'd0, irq_take}, {31'd0, hit});
        tick();
        hw_irq = '0;
        if (hit) begin
          exp_code = 5'd0;
          exp_epc  = 32'h2000 + 32'(j * 16 + i);
        end
        check("R6 level", {31'd0, exc_level}, {31'd0, hit});
        rd("R6 code", 5'd13, 32'(exp_code) << 2);
        check("R6 epc", ret_pc, exp_epc);
      end
    end

    // R5 software level 0 through cause bit 8
    wr(5'd12, 32'h0000_0101);
    cur_pc = 32'h3000;
    wr(5'd13, 32'h0000_0100);
    check("R5 sw irq", {31'd0, irq_take}, 32'h1);
    tick();
    wr(5'd13, 32'h0);
    check("R6 sw taken", {31'd0, exc_level}, 32'h1);
    check("R6 sw epc", ret_pc, 32'h3000);

    // R5 enable and level gate
    wr(5'd12, 32'h0000_FF00);
    hw_irq = 6'h01; #1;
    check("R5 ie off", {31'd0, irq_take}, 32'h0);
    hw_irq = '0;
    wr(5'd12, 32'h0000_FF03);
    hw_irq = 6'h01; #1;
    check("R5 level blocks", {31'd0, irq_take}, 32'h0);
    rd("R5 pending shown", 5'd13, 32'h0000_0400);
    hw_irq = '0;

    // R7 exception beats interrupt
    wr(5'd12, 32'h0000_FF01);
    hw_irq = 6'h20; cur_pc = 32'h4000; #1;
    check("R7 irq alone", {31'd0, irq_take}, 32'h1);
    exc_valid = 1'b1; exc_code = 5'd8; #1;
    check("R7 irq suppressed", {31'd0, irq_take}, 32'h0);
    tick();
    exc_valid = 1'b0; hw_irq = '0;
    rd("R7 code", 5'd13, 32'd8 << 2);
    check("R7 epc", ret_pc, 32'h4000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule